// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Target

This block is the bus-facing logic of a 4096-byte nonvolatile store on a two-wire serial bus (I2C). It oversamples the clock and data lines with the system clock and recognises start and stop conditions. It then decodes a control byte, and drives the data line low whenever it acknowledges or sends a zero. A three-pin device select lets eight such targets share one bus. Only the target whose pins match the select bits in the control byte responds.

A write transaction sets a 12-bit word address and fills a 32-entry page latch. After the stop condition, a self-timed busy window of a fixed number of clock cycles moves the latched bytes into the storage array, which is modelled as a synchronous RAM. During that window the target refuses its control byte, so a master finds out when the write has finished by repeating the control byte until it is acknowledged. Reads can start at a new address by way of a dummy write followed by a repeated start. They can also continue from the address counter that the last transfer left behind, and they stream on byte by byte across the whole array.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the target leaves SDA released (`sda_low` = 0) and waits for a start condition.
- R2: A control byte is acknowledged (SDA low during the ninth clock) only if its upper four bits are 1010 and bits 3..1 equal `dev_sel`. Bit 0 selects the direction, with 1 meaning read. Any other control byte gets no acknowledge. All bytes travel MSB first.
- R3: A write transaction sends two address bytes after the control byte, high byte first. Only the low 4 bits of the high byte are used, and the upper 4 are ignored.
- R4: A single data byte followed by stop changes only that one location of the array.
- R5: The target accepts and acknowledges up to 32 data bytes. The low 5 address bits advance after each byte and wrap inside the current 32-byte page, and the upper 7 bits stay fixed.
- R6: After a stop that ends a write holding data, the target is busy for exactly `WRITE_CYCLES` clock cycles and acknowledges no control byte during that time.
- R7: While `wp_in` is high at the stop, data bytes are still acknowledged, but the array is not changed and no busy window starts.
- R8: A repeated start returns the target to the control-byte phase and throws away latched write data without committing it. The address counter keeps its value.
- R9: Each byte read advances the address counter by one, and the counter wraps from 4095 to 0.
- R10: A read that begins without setting an address returns data from the address counter left by the previous transfer.
- R11: During a read the target shifts out each byte MSB first. If the master does not acknowledge a byte, the target releases SDA and sends nothing more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired-AND of all drivers) |
| dev_sel | input | 3 | Device-select strap pins |
| wp_in | input | 1 | Write protect, 1 blocks array updates |
| sda_low | output | 1 | 1 = target pulls SDA low |

## Verification
The hardest situation to reach from the ports is the interplay of the busy window with bus traffic. That covers a control byte arriving while a commit is still running, a write-protected stop that must not open the window, and a repeated start that must drop latched bytes. The bench reaches these states by issuing a control byte straight after the stop of a write and checking the acknowledge bit, first with protection off and then with protection on. In a further step it performs a dummy write that carries one data byte, then switches to a read with a repeated start. The address-counter rollover is reached by writing the last two locations and location 0, then reading across the boundary in two separate transactions.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam int unsigned DEF_ADDR_W = 12;
    localparam int unsigned DEF_PAGE_W = 5;
    localparam logic [3:0]  CTRL_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_AHI,
        PH_ALO,
        PH_WDATA,
        PH_RDATA
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    function automatic logic ctrl_match(input logic [7:0] b, input logic [2:0] sel);
        return (b[7:4] == CTRL_PREFIX) && (b[3:1] == sel);
    endfunction

endpackage

// File: rtl/bus_sampler.sv
module bus_sampler
    import eeprom_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_prev, sda_prev;
    logic scl_cur, sda_cur;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_in;
                    sda_sh <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
                    sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_cur = scl_sh[SYNC_STAGES-1];
    assign sda_cur = sda_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_cur;
            sda_prev <= sda_cur;
        end
    end

    always_comb begin
        ev.scl   = scl_cur;
        ev.sda   = sda_cur;
        ev.rise  = ~scl_prev & scl_cur;
        ev.fall  = scl_prev & ~scl_cur;
        ev.start = scl_prev & scl_cur & sda_prev & ~sda_cur;
        ev.stop  = scl_prev & scl_cur & ~sda_prev & sda_cur;
    end
endmodule

// File: rtl/page_latch.sv
module page_latch #(
    parameter int unsigned PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              clr,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    localparam int unsigned ENTRIES = 1 << PAGE_W;

    logic [7:0]         data_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) data_q[wr_idx] <= wr_data;
    end

    assign rd_data   = data_q[rd_idx];
    assign rd_valid  = valid_q[rd_idx];
    assign any_valid = |valid_q;
endmodule

// File: rtl/commit_timer.sv
module commit_timer #(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned PAGE_W       = 5,
    parameter int unsigned WRITE_CYCLES = 100000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     launch,
    input  logic [ADDR_W-PAGE_W-1:0] page_base,
    output logic [PAGE_W-1:0]        rd_idx,
    input  logic [7:0]               rd_data,
    input  logic                     rd_valid,
    output logic                     busy,
    output logic                     done,
    output logic                     ram_we,
    output logic [ADDR_W-1:0]        ram_addr,
    output logic [7:0]               ram_wdata
);
    localparam int unsigned CW         = $clog2(WRITE_CYCLES + 1);
    localparam int unsigned PAGE_BYTES = 1 << PAGE_W;

    logic [CW-1:0]            cnt_q;
    logic [ADDR_W-PAGE_W-1:0] base_q;
    logic                     in_copy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            base_q <= '0;
        end else if (!busy) begin
            if (launch) begin
                busy   <= 1'b1;
                cnt_q  <= '0;
                base_q <= page_base;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (done) busy <= 1'b0;
        end
    end

    assign in_copy   = busy && (cnt_q < CW'(PAGE_BYTES));
    assign rd_idx    = cnt_q[PAGE_W-1:0];
    assign ram_we    = in_copy && rd_valid;
    assign ram_addr  = {base_q, cnt_q[PAGE_W-1:0]};
    assign ram_wdata = rd_data;
    assign done      = busy && (cnt_q == CW'(WRITE_CYCLES - 1));
endmodule

// File: rtl/byte_ram.sv
module byte_ram #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import eeprom_pkg::*;
#(
    parameter int unsigned ADDR_W       = DEF_ADDR_W,
    parameter int unsigned PAGE_W       = DEF_PAGE_W,
    parameter int unsigned WRITE_CYCLES = 100000,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] dev_sel,
    input  logic       wp_in,
    output logic       sda_low
);
    localparam int unsigned HI_W = ADDR_W - 8;

    bus_ev_t ev;

    phase_t            phase_q;
    logic [3:0]        bitcnt_q;
    logic [7:0]        shreg_q;
    logic [7:0]        txsh_q;
    logic              rw_q;
    logic              mack_q;
    logic [ADDR_W-1:0] addr_q;
    logic [HI_W-1:0]   ahi_q;

    logic              lat_we, lat_clr, lat_any;
    logic [PAGE_W-1:0] cm_idx;
    logic [7:0]        cm_data;
    logic              cm_valid;
    logic              launch, busy, commit_done;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [7:0]        ram_wdata, ram_q;

    bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    page_latch #(.PAGE_W(PAGE_W)) u_latch (
        .clk(clk), .rst(rst),
        .we(lat_we), .wr_idx(addr_q[PAGE_W-1:0]), .wr_data(shreg_q),
        .clr(lat_clr),
        .rd_idx(cm_idx), .rd_data(cm_data), .rd_valid(cm_valid),
        .any_valid(lat_any)
    );

    commit_timer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_commit (
        .clk(clk), .rst(rst),
        .launch(launch), .page_base(addr_q[ADDR_W-1:PAGE_W]),
        .rd_idx(cm_idx), .rd_data(cm_data), .rd_valid(cm_valid),
        .busy(busy), .done(commit_done),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    byte_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_addr), .wdata(ram_wdata),
        .raddr(addr_q), .rdata(ram_q)
    );

    // Byte completes on the falling edge after the eighth rising edge.
    assign lat_we  = !ev.start && !ev.stop && ev.fall &&
                     (bitcnt_q == 4'd8) && (phase_q == PH_WDATA);
    assign launch  = ev.stop && !busy && lat_any && !wp_in;
    assign lat_clr = commit_done || (!busy && (ev.start || (ev.stop && !launch)));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            txsh_q   <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            addr_q   <= '0;
            ahi_q    <= '0;
            sda_low  <= 1'b0;
        end else if (ev.start) begin
            phase_q  <= PH_CTRL;
            bitcnt_q <= '0;
            sda_low  <= 1'b0;
        end else if (ev.stop) begin
            phase_q  <= PH_IDLE;
            bitcnt_q <= '0;
            sda_low  <= 1'b0;
        end else if (phase_q != PH_IDLE) begin
            if (ev.rise) begin
                if (bitcnt_q != 4'd9) bitcnt_q <= bitcnt_q + 1'b1;
                if (bitcnt_q < 4'd8)  shreg_q  <= {shreg_q[6:0], ev.sda};
                if (bitcnt_q == 4'd8) mack_q   <= ~ev.sda;
            end else if (ev.fall) begin
                if (bitcnt_q == 4'd8) begin
                    unique case (phase_q)
                        PH_CTRL: begin
                            if (ctrl_match(shreg_q, dev_sel) && !busy) begin
                                sda_low <= 1'b1;
                                rw_q    <= shreg_q[0];
                            end else begin
                                phase_q <= PH_IDLE;
                            end
                        end
                        PH_AHI: begin
                            ahi_q   <= shreg_q[HI_W-1:0];
                            sda_low <= 1'b1;
                        end
                        PH_ALO: begin
                            addr_q  <= {ahi_q, shreg_q};
                            sda_low <= 1'b1;
                        end
                        PH_WDATA: begin
                            addr_q  <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
                            sda_low <= 1'b1;
                        end
                        default: sda_low <= 1'b0;
                    endcase
                end else if (bitcnt_q == 4'd9) begin
                    bitcnt_q <= '0;
                    sda_low  <= 1'b0;
                    unique case (phase_q)
                        PH_CTRL: begin
                            if (rw_q) begin
                                phase_q <= PH_RDATA;
                                txsh_q  <= ram_q;
                                sda_low <= ~ram_q[7];
                                addr_q  <= addr_q + 1'b1;
                            end else begin
                                phase_q <= PH_AHI;
                            end
                        end
                        PH_AHI:   phase_q <= PH_ALO;
                        PH_ALO:   phase_q <= PH_WDATA;
                        PH_RDATA: begin
                            if (mack_q) begin
                                txsh_q  <= ram_q;
                                sda_low <= ~ram_q[7];
                                addr_q  <= addr_q + 1'b1;
                            end else begin
                                phase_q <= PH_IDLE;
                            end
                        end
                        default: phase_q <= phase_q;
                    endcase
                end else if (phase_q == PH_RDATA) begin
                    sda_low <= ~txsh_q[6];
                    txsh_q  <= {txsh_q[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/eeprom_checker.sv
module eeprom_checker
    import eeprom_pkg::*;
#(
    parameter int unsigned WRITE_CYCLES = 100000
) (
    input logic    clk,
    input logic    rst,
    input logic    sda_low,
    input logic    wp_in,
    input bus_ev_t ev,
    input phase_t  phase_q,
    input logic    busy,
    input logic    launch,
    input logic    ram_we
);
    int unsigned busy_len;

    always_ff @(posedge clk) begin
        if (rst)       busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    a_r1_released_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !sda_low);

    a_r11_sda_moves_while_scl_low: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_low) && !ev.start && !ev.stop) |-> !ev.scl);

    a_r6_busy_window_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == WRITE_CYCLES));

    a_r6_no_ack_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && phase_q == PH_CTRL) |-> !sda_low);

    a_r7_protect_blocks_launch: assert property (@(posedge clk) disable iff (rst)
        launch |-> !wp_in);

    a_r4_array_written_only_in_window: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> busy);
endmodule

bind i2c_eeprom_target eeprom_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_checker (
    .clk(clk), .rst(rst), .sda_low(sda_low), .wp_in(wp_in), .ev(ev),
    .phase_q(phase_q), .busy(busy), .launch(launch), .ram_we(ram_we)
);

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;
    localparam int Q  = 8;
    localparam int WC = 400;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] CTRL_W = 8'hAA;
    localparam logic [7:0] CTRL_R = 8'hAB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_line;
    logic sda_low;

    int checks = 0;
    int errors = 0;
    int last_polls;
    logic [7:0] wbuf [32];
    logic [7:0] rbuf [32];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_low;

    i2c_eeprom_target #(.WRITE_CYCLES(WC)) uut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .dev_sel(SEL), .wp_in(wp), .sda_low(sda_low)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl = 1'b1;   wq(2*Q);
            scl = 1'b0;   wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        ack = ~sda_line;
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q);
            scl = 1'b1;   wq(Q);
            b[i] = sda_line;
            wq(Q);
            scl = 1'b0;   wq(Q);
        end
        sda_m = ~give_ack; wq(Q);
        scl = 1'b1;        wq(2*Q);
        scl = 1'b0;        wq(Q);
        sda_m = 1'b1;
    endtask

    // Leaves the bus with an acknowledged write control byte.
    task automatic wait_ready;
        logic ack;
        ack = 1'b0;
        last_polls = 0;
        while (!ack && last_polls < 20) begin
            bus_start;
            send_byte(CTRL_W, ack);
            last_polls++;
            if (!ack) bus_stop;
        end
        check(ack, "R6 target becomes ready after busy window", ack, 1);
    endtask

    task automatic write_seq(input logic [7:0] hi, input logic [7:0] lo, input int n);
        logic ack;
        wait_ready;
        send_byte(hi, ack);
        check(ack, "R3 high address byte acknowledged", ack, 1);
        send_byte(lo, ack);
        check(ack, "R3 low address byte acknowledged", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            check(ack, "R5 data byte acknowledged", ack, 1);
        end
        bus_stop;
    endtask

    task automatic read_seq(input logic [7:0] hi, input logic [7:0] lo, input int n);
        logic ack;
        wait_ready;
        send_byte(hi, ack);
        send_byte(lo, ack);
        bus_start;
        send_byte(CTRL_R, ack);
        check(ack, "R2 read control byte acknowledged", ack, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop;
    endtask

    task automatic t_reset;
        wq(3);
        check(sda_low == 1'b0, "R1 SDA released after reset", sda_low, 0);
    endtask

    task automatic t_select;
        logic ack;
        bus_start; send_byte(CTRL_W, ack); bus_stop;
        check(ack == 1'b1, "R2 matching control byte acknowledged", ack, 1);
        bus_start; send_byte(8'hA4, ack); bus_stop;
        check(ack == 1'b0, "R2 wrong select bits not acknowledged", ack, 0);
        bus_start; send_byte(8'hBA, ack); bus_stop;
        check(ack == 1'b0, "R2 wrong prefix not acknowledged", ack, 0);
    endtask

    task automatic t_page;
        for (int i = 0; i < 32; i++) wbuf[i] = 8'h40 + 8'(i);
        write_seq(8'h01, 8'h30, 32);
        read_seq(8'h01, 8'h20, 32);
        for (int o = 0; o < 32; o++) begin
            logic [7:0] exp;
            exp = 8'h40 + 8'((o - 16) & 31);
            check(rbuf[o] == exp, "R5 page wrap placement", rbuf[o], exp);
        end
        check(rbuf[31] == 8'h4F, "R11 last page byte read MSB first", rbuf[31], 8'h4F);
    endtask

    task automatic t_byte;
        logic ack;
        wbuf[0] = 8'hA5;
        write_seq(8'hF1, 8'h25, 1);
        bus_start; send_byte(CTRL_W, ack); bus_stop;
        check(ack == 1'b0, "R6 control byte refused during busy window", ack, 0);
        read_seq(8'h01, 8'h24, 3);
        check(last_polls > 1 || ack == 1'b0, "R6 polling needed", last_polls, 2);
        check(rbuf[0] == 8'h54, "R4 lower neighbour unchanged", rbuf[0], 8'h54);
        check(rbuf[1] == 8'hA5, "R4 R3 byte written at 0x125", rbuf[1], 8'hA5);
        check(rbuf[2] == 8'h56, "R4 upper neighbour unchanged", rbuf[2], 8'h56);
    endtask

    task automatic t_wp;
        logic ack;
        wp = 1'b1;
        wbuf[0] = 8'h11;
        write_seq(8'h01, 8'h25, 1);
        bus_start; send_byte(CTRL_W, ack); bus_stop;
        check(ack == 1'b1, "R7 no busy window under protect", ack, 1);
        read_seq(8'h01, 8'h25, 1);
        check(rbuf[0] == 8'hA5, "R7 protected location unchanged", rbuf[0], 8'hA5);
        wp = 1'b0;
    endtask

    task automatic t_restart;
        logic ack;
        logic [7:0] b;
        wait_ready;
        send_byte(8'h01, ack);
        send_byte(8'h26, ack);
        send_byte(8'h99, ack);
        check(ack == 1'b1, "R8 data byte before restart acknowledged", ack, 1);
        bus_start;
        send_byte(CTRL_R, ack);
        recv_byte(1'b0, b);
        bus_stop;
        check(b == 8'h57, "R8 read after restart continues from counter", b, 8'h57);
        bus_start; send_byte(CTRL_W, ack); bus_stop;
        check(ack == 1'b1, "R8 restart left no commit pending", ack, 1);
        read_seq(8'h01, 8'h26, 1);
        check(rbuf[0] == 8'h56, "R8 discarded byte not written", rbuf[0], 8'h56);
    endtask

    task automatic t_rollover;
        logic ack;
        logic [7:0] b;
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        write_seq(8'h0F, 8'hFE, 2);
        wbuf[0] = 8'h99;
        write_seq(8'h00, 8'h00, 1);
        read_seq(8'h0F, 8'hFE, 2);
        check(rbuf[0] == 8'h77, "R9 read at 0xFFE", rbuf[0], 8'h77);
        check(rbuf[1] == 8'h88, "R9 sequential read at 0xFFF", rbuf[1], 8'h88);
        check(sda_low == 1'b0, "R11 SDA released after master NACK", sda_low, 0);
        wait_ready;
        bus_start;
        send_byte(CTRL_R, ack);
        recv_byte(1'b0, b);
        bus_stop;
        check(b == 8'h99, "R10 R9 current-address read after rollover", b, 8'h99);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 180000) begin
            @(posedge clk);
            cyc++;
        end
        checks++;
        errors++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wq(5);
        rst = 1'b0;
        t_reset;
        t_select;
        t_page;
        t_byte;
        t_wp;
        t_restart;
        t_rollover;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule